// File: doc/BRIEF.md
# Doorbell Page Write Decoder

This block sits behind the register-write path of a 4 KB doorbell page owned by one protection domain. A host or guest writes a 32-bit word. The block works out which of ten doorbells the write lands on and pulls that doorbell's fields out of the data word. It then hands a single command to the queue engines through a valid/ready output. Each doorbell owns a 32-byte slot, and only the first word of a slot is live. The first slot starts at byte offset 0x40.

Three kinds of write are filtered before anything reaches the queue engines. A write from the wrong domain raises a one-cycle access-violation pulse. A write with a reserved bit set raises a one-cycle bad-queue-id pulse. A write to an unused location is dropped without any signal. The write input stalls while a command is waiting on the output and the consumer has not taken it.

Top module: `db_page_decoder`

## Requirements
- R1: After reset, cmd_valid, err_bad_qid and err_access are low and wr_ready is high.
- R2: A write is accepted on a clock edge where wr_valid and wr_ready are both high. An accepted write to page offset 0x40 + 32*k, for k from 0 to 9, produces cmd_kind = k after that edge. The kinds, in slot order, are: RDMA send, storage work-request post, Ethernet transmit, RDMA receive, storage default-PDU, TPM receive, Ethernet receive, completion/event queue, management ring and bootstrap mailbox.
- R3: For send-type kinds (0, 2, 8), cmd_qid = data[10:0] and cmd_count = data[29:16]. Bits 15:11 and 31:30 are reserved.
- R4: For receive kinds (3, 6), cmd_qid = data[9:0], cmd_flags[0] = data[23] (invalidate) and cmd_count = data[31:24]. Bits 22:10 are reserved.
- R5: For the completion/event kind (7), cmd_qid = data[9:0], cmd_flags[0] = data[14] (rearm), cmd_flags[1] = data[15] (event) and cmd_count = data[28:16]. Bits 13:10 and 31:29 are reserved. The default-PDU kind (4) uses the same layout, except that its count is data[29:16] and its reserved high bits are 31:30.
- R6: For the work-request post kind (1), cmd_qid = data[9:0], cmd_aux = data[23:16] (slot index) and cmd_count = data[31:24]. For the TPM receive kind (5), cmd_qid = data[9:0], cmd_count = data[26:16] and cmd_aux = data[31:27] (segment count). For both kinds, bits 15:10 are reserved.
- R7: For the mailbox kind (9), cmd_flags[0] = data[1] (high half), cmd_flags[1] = data[0] (ready) and cmd_aux = data[31:2]. This kind has no reserved bits. Unused output fields read zero for every kind.
- R8: If an accepted, in-domain write to a live slot has any reserved bit set, err_bad_qid is high for exactly the one cycle after the accepting edge, and no command is issued.
- R9: The write address carries the domain index in bits [16:12] and the page offset in bits [11:0]. If the domain index differs from grant_domain, err_access is high for one cycle and no command is issued. This check takes precedence over R8.
- R10: An accepted write to an offset outside the ten slots, or to bytes 4 to 31 of any slot, produces no command and no error.
- R11: While cmd_valid is high and cmd_ready is low, wr_ready is low and every cmd_* output holds steady. When a command is consumed on the same edge that a new write is accepted, the next command follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_addr | input | 17 | Domain index [16:12], byte offset in page [11:0] |
| wr_data | input | 32 | Doorbell data word |
| grant_domain | input | 5 | Domain granted to the requester |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_kind | output | 4 | Doorbell kind 0 to 9 |
| cmd_qid | output | 11 | Queue or connection id |
| cmd_count | output | 14 | Posted or popped count |
| cmd_flags | output | 2 | Per-kind flag bits |
| cmd_aux | output | 30 | Per-kind extra field |
| err_bad_qid | output | 1 | Reserved-bit violation pulse |
| err_access | output | 1 | Cross-domain write pulse |

## Verification
A single write can break both the domain check and the reserved-bit check. The bench sends a foreign-domain write to the completion/event slot with reserved bits set, and expects the access-violation pulse alone. The second coincidence is the output draining on the same edge that a new write is accepted. The bench holds cmd_ready low with a second write pending, confirms that the first command stays frozen, then raises cmd_ready. It judges the result by the second command appearing one cycle later and the output emptying one cycle after that.

// File: rtl/db_page_decoder.sv
module db_page_decoder #(
  parameter int DOM_W     = 5,
  parameter int PAGE_W    = 12,
  parameter int SLOT_BASE = 'h40,
  parameter int NUM_KINDS = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [DOM_W+PAGE_W-1:0] wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [DOM_W-1:0]        grant_domain,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [3:0]              cmd_kind,
  output logic [10:0]             cmd_qid,
  output logic [13:0]             cmd_count,
  output logic [1:0]              cmd_flags,
  output logic [29:0]             cmd_aux,
  output logic                    err_bad_qid,
  output logic                    err_access
);
  localparam int SLOT_W = PAGE_W - 5;
  localparam logic [PAGE_W-1:0] BASE      = PAGE_W'(SLOT_BASE);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_KINDS - 1);

  localparam logic [31:0] MASK_SEND = 32'hC000_F800;
  localparam logic [31:0] MASK_WRB  = 32'h0000_FC00;
  localparam logic [31:0] MASK_RECV = 32'h007F_FC00;
  localparam logic [31:0] MASK_PDU  = 32'hC000_3C00;
  localparam logic [31:0] MASK_CQ   = 32'hE000_3C00;

  logic [PAGE_W-1:0] off, rel;
  logic [SLOT_W-1:0] slot;
  logic [DOM_W-1:0]  dom;
  logic              accept, dom_ok, live, rsvd_hit, issue;
  logic [10:0]       d_qid;
  logic [13:0]       d_count;
  logic [1:0]        d_flags;
  logic [29:0]       d_aux;
  logic [31:0]       d_mask;

  assign off      = wr_addr[PAGE_W-1:0];
  assign dom      = wr_addr[DOM_W+PAGE_W-1:PAGE_W];
  assign rel      = off - BASE;
  assign slot     = rel[PAGE_W-1:5];
  assign live     = (off >= BASE) && (slot <= LAST_SLOT) && (rel[4:0] == 5'd0);
  assign dom_ok   = (dom == grant_domain);
  assign rsvd_hit = |(wr_data & d_mask);
  assign wr_ready = !cmd_valid || cmd_ready;
  assign accept   = wr_valid && wr_ready;
  assign issue    = dom_ok && live && !rsvd_hit;

  always_comb begin
    d_qid   = '0;
    d_count = '0;
    d_flags = '0;
    d_aux   = '0;
    d_mask  = '0;
    case (slot[3:0])
      4'd0, 4'd2, 4'd8: begin
        d_qid   = wr_data[10:0];
        d_count = wr_data[29:16];
        d_mask  = MASK_SEND;
      end
      4'd1: begin
        d_qid   = {1'b0, wr_data[9:0]};
        d_count = {6'b0, wr_data[31:24]};
        d_aux   = {22'b0, wr_data[23:16]};
        d_mask  = MASK_WRB;
      end
      4'd3, 4'd6: begin
        d_qid   = {1'b0, wr_data[9:0]};
        d_count = {6'b0, wr_data[31:24]};
        d_flags = {1'b0, wr_data[23]};
        d_mask  = MASK_RECV;
      end
      4'd4: begin
        d_qid   = {1'b0, wr_data[9:0]};
        d_count = wr_data[29:16];
        d_flags = wr_data[15:14];
        d_mask  = MASK_PDU;
      end
      4'd5: begin
        d_qid   = {1'b0, wr_data[9:0]};
        d_count = {3'b0, wr_data[26:16]};
        d_aux   = {25'b0, wr_data[31:27]};
        d_mask  = MASK_WRB;
      end
      4'd7: begin
        d_qid   = {1'b0, wr_data[9:0]};
        d_count = {1'b0, wr_data[28:16]};
        d_flags = wr_data[15:14];
        d_mask  = MASK_CQ;
      end
      4'd9: begin
        d_flags = {wr_data[0], wr_data[1]};
        d_aux   = wr_data[31:2];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_kind    <= '0;
      cmd_qid     <= '0;
      cmd_count   <= '0;
      cmd_flags   <= '0;
      cmd_aux     <= '0;
      err_bad_qid <= 1'b0;
      err_access  <= 1'b0;
    end else begin
      err_bad_qid <= accept && dom_ok && live && rsvd_hit;
      err_access  <= accept && !dom_ok;
      if (accept) begin
        cmd_valid <= issue;
        if (issue) begin
          cmd_kind  <= slot[3:0];
          cmd_qid   <= d_qid;
          cmd_count <= d_count;
          cmd_flags <= d_flags;
          cmd_aux   <= d_aux;
        end
      end else if (cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_qid)
                                && $stable(cmd_count) && $stable(cmd_flags) && $stable(cmd_aux));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && wr_valid |=> cmd_valid && $stable(cmd_qid));

  assert_kind_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_kind <= 4'(NUM_KINDS - 1));

  assert_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_access && err_bad_qid));

  assert_no_cmd_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !err_bad_qid && !err_access);

  assert_err_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_access |-> $past(wr_valid));

  assert_send_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == 4'd0 || cmd_kind == 4'd2 || cmd_kind == 4'd8)
      |-> cmd_flags == 2'b00 && cmd_aux == '0);
endmodule

// File: tb/db_page_decoder_test.sv
module db_page_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [16:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  grant_domain = 5'd3;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [3:0]  cmd_kind;
  logic [10:0] cmd_qid;
  logic [13:0] cmd_count;
  logic [1:0]  cmd_flags;
  logic [29:0] cmd_aux;
  logic        err_bad_qid, err_access;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  db_page_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .grant_domain(grant_domain),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_qid(cmd_qid), .cmd_count(cmd_count), .cmd_flags(cmd_flags),
    .cmd_aux(cmd_aux), .err_bad_qid(err_bad_qid), .err_access(err_access)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [11:0] off;
    logic [31:0] data;
    logic [1:0]  res;
    logic [3:0]  kind;
    logic [10:0] qid;
    logic [13:0] cnt;
    logic [1:0]  flg;
    logic [29:0] aux;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{12'h040, 32'h1234_05A5, 2'd0, 4'd0, 11'h5A5, 14'h1234, 2'd0, 30'h0},
    '{12'h060, 32'hAB7F_03C1, 2'd0, 4'd1, 11'h3C1, 14'h00AB, 2'd0, 30'h7F},
    '{12'h080, 32'h3FFF_07FF, 2'd0, 4'd2, 11'h7FF, 14'h3FFF, 2'd0, 30'h0},
    '{12'h0A0, 32'h5A80_0155, 2'd0, 4'd3, 11'h155, 14'h005A, 2'd1, 30'h0},
    '{12'h0C0, 32'h2ABC_8123, 2'd0, 4'd4, 11'h123, 14'h2ABC, 2'd2, 30'h0},
    '{12'h0E0, 32'hF801_0200, 2'd0, 4'd5, 11'h200, 14'h0001, 2'd0, 30'h1F},
    '{12'h100, 32'h0100_03FF, 2'd0, 4'd6, 11'h3FF, 14'h0001, 2'd0, 30'h0},
    '{12'h120, 32'h1FFF_C00A, 2'd0, 4'd7, 11'h00A, 14'h1FFF, 2'd3, 30'h0},
    '{12'h140, 32'h0005_0001, 2'd0, 4'd8, 11'h001, 14'h0005, 2'd0, 30'h0},
    '{12'h160, 32'hFFFF_FFFE, 2'd0, 4'd9, 11'h000, 14'h0000, 2'd1, 30'h3FFF_FFFF},
    '{12'h120, 32'h2000_0000, 2'd1, 4'd0, 11'h0, 14'h0, 2'd0, 30'h0},
    '{12'h040, 32'h0000_0800, 2'd1, 4'd0, 11'h0, 14'h0, 2'd0, 30'h0},
    '{12'h0A0, 32'h0040_0000, 2'd1, 4'd0, 11'h0, 14'h0, 2'd0, 30'h0},
    '{12'h060, 32'h0000_0400, 2'd1, 4'd0, 11'h0, 14'h0, 2'd0, 30'h0},
    '{12'h000, 32'h0000_0001, 2'd2, 4'd0, 11'h0, 14'h0, 2'd0, 30'h0},
    '{12'h044, 32'h0000_0001, 2'd2, 4'd0, 11'h0, 14'h0, 2'd0, 30'h0},
    '{12'h07C, 32'h0000_0001, 2'd2, 4'd0, 11'h0, 14'h0, 2'd0, 30'h0},
    '{12'h180, 32'h0000_0001, 2'd2, 4'd0, 11'h0, 14'h0, 2'd0, 30'h0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_once(input logic [4:0] dom, input logic [11:0] off, input logic [31:0] data);
    @(negedge clk);
    wr_addr  = {dom, off};
    wr_data  = data;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!cmd_valid, "R1 cmd_valid", 64'(cmd_valid), 0);
    check(!err_bad_qid && !err_access, "R1 errors", {err_bad_qid, err_access}, 0);
    check(wr_ready, "R1 wr_ready", 64'(wr_ready), 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      write_once(5'd3, VEC[i].off, VEC[i].data);
      if (VEC[i].res == 2'd0) begin
        // R2 R3 R4 R5 R6 R7 decode and fields
        check(cmd_valid && !err_bad_qid && !err_access, "R2 command issued", {cmd_valid, err_bad_qid, err_access}, 3'b100);
        check(cmd_kind == VEC[i].kind, "R2 kind", cmd_kind, VEC[i].kind);
        check(cmd_qid == VEC[i].qid, "R3-style qid field", cmd_qid, VEC[i].qid);
        check(cmd_count == VEC[i].cnt, "R5 count field", cmd_count, VEC[i].cnt);
        check(cmd_flags == VEC[i].flg, "R4 flags field", cmd_flags, VEC[i].flg);
        check(cmd_aux == VEC[i].aux, "R6 R7 aux field", cmd_aux, VEC[i].aux);
      end else if (VEC[i].res == 2'd1) begin
        check(err_bad_qid && !cmd_valid && !err_access, "R8 reserved bit rejected", {err_bad_qid, cmd_valid, err_access}, 3'b100);
        @(negedge clk);
        check(!err_bad_qid, "R8 single-cycle pulse", 64'(err_bad_qid), 0);
      end else begin
        check(!cmd_valid && !err_bad_qid && !err_access, "R10 dropped", {cmd_valid, err_bad_qid, err_access}, 0);
      end
    end

    // R9 foreign domain with reserved bits set: access error only
    write_once(5'd7, 12'h120, 32'hE000_0000);
    check(err_access && !err_bad_qid && !cmd_valid, "R9 domain precedence", {err_access, err_bad_qid, cmd_valid}, 3'b100);
    @(negedge clk);
    check(!err_access, "R9 single-cycle pulse", 64'(err_access), 0);
    write_once(5'd0, 12'h040, 32'h0001_0001);
    check(err_access && !cmd_valid, "R9 clean write foreign domain", {err_access, cmd_valid}, 2'b10);

    // R11 back-pressure and same-edge drain plus accept
    @(negedge clk);
    cmd_ready = 1'b0;
    write_once(5'd3, 12'h140, 32'h0002_0011);
    check(cmd_valid && cmd_qid == 11'h011, "R11 first command", {cmd_valid, cmd_qid}, {1'b1, 11'h011});
    wr_addr  = {5'd3, 12'h080};
    wr_data  = 32'h0003_0022;
    wr_valid = 1'b1;
    check(!wr_ready, "R11 wr_ready low", 64'(wr_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(cmd_valid && cmd_kind == 4'd8 && cmd_qid == 11'h011 && cmd_count == 14'd2,
            "R11 held command", {cmd_kind, cmd_qid}, {4'd8, 11'h011});
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    check(cmd_valid && cmd_kind == 4'd2 && cmd_qid == 11'h022 && cmd_count == 14'd3,
          "R11 back-to-back command", {cmd_kind, cmd_qid}, {4'd2, 11'h022});
    @(negedge clk);
    check(!cmd_valid, "R11 drained", 64'(cmd_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule